// File: doc/BRIEF.md
# Buffer-Occupancy Throughput Adaptation Controller

This block picks between cipher datapath configurations of different pipeline depth by watching how full the input block buffer is. A configuration index selects the depth: index 0 is one stage, index 1 two stages, index 2 four stages, and each step up doubles throughput. The block never acts on a single sample of the buffer level. On every encryption iteration it casts a ternary vote: "speed up" when the buffer is nearly full, "slow down" when it is nearly empty, "no opinion" inside a dead band. Once every frame of iterations it compares the vote counts with a supermajority limit and asks for a single index step if one side has won.

A request stays raised, with a steady target index, until the surrounding controller acknowledges it. While it is raised no new votes are counted. After the acknowledgement a fresh frame starts. A hold input selects the guaranteed-throughput policy, under which the configuration is never changed. With the hold low (best effort), the block steps down to a slower, more energy-efficient configuration when the buffer stays low and steps up when it stays high.

Top module: `occ_rate_governor`

## Requirements
- R1: After reset `req_valid` is 0 and `target_idx` is 0.
- R2: On an iteration, an occupancy strictly below LOW_TH (default 2) is a slow-down vote, strictly above HIGH_TH (default 14) is a speed-up vote, and any value from LOW_TH to HIGH_TH inclusive is no vote.
- R3: Only cycles with `iter_pulse` high count as iterations; the decision is taken on the FRAME_LEN-th (default 256) counted iteration and `req_valid` can only rise in the cycle after such an iteration.
- R4: If speed-up votes in the frame exceed VOTE_LIMIT (default 187), `req_valid` rises with `target_idx` = `cur_idx` + 1; exactly VOTE_LIMIT votes give no request.
- R5: If slow-down votes in the frame exceed VOTE_LIMIT, `req_valid` rises with `target_idx` = `cur_idx` - 1.
- R6: No speed-up request is made when `cur_idx` equals `max_idx`, and no slow-down request when it equals `min_idx`; a target always lies within [`min_idx`, `max_idx`].
- R7: While `hold_rate` is 1 at the end of a frame, no request is made whatever the votes.
- R8: A raised request keeps `req_valid` high and `target_idx` unchanged until a cycle with `req_ack` high, after which `req_valid` is 0; iterations during a pending request are not counted, and a new frame starts from zero after the acknowledgement.
- R9: Vote counts do not carry from one frame into the next.
- R10: Each request moves the index by exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| occupancy | input | OCC_W (5) | Number of filled entries in the input block buffer (0..16) |
| iter_pulse | input | 1 | One-cycle mark of an encryption iteration |
| cur_idx | input | IDX_W (2) | Configuration index now in use |
| min_idx | input | IDX_W (2) | Lowest index allowed |
| max_idx | input | IDX_W (2) | Highest index allowed |
| hold_rate | input | 1 | 1 = guaranteed-throughput policy, keep the configuration |
| req_ack | input | 1 | Acknowledge of the pending request |
| req_valid | output | 1 | Reconfiguration request pending |
| target_idx | output | IDX_W (2) | Index requested |

## Verification
The assertions assume that `cur_idx`, `min_idx` and `max_idx` satisfy min ≤ cur ≤ max and that `cur_idx` does not change while a request is pending, since the one-step and range properties compare the target with the index seen when the request rose. The bench keeps to this by drawing bounds with min below max, picking the current index between them, and updating `cur_idx` to the granted target only after the acknowledgement cycle. Occupancy is drawn within 0..16 and iteration pulses are at most one cycle wide.

// File: rtl/occ_rate_pkg.sv
package occ_rate_pkg;
    typedef enum logic [1:0] {
        VOTE_NONE = 2'd0,
        VOTE_UP   = 2'd1,
        VOTE_DOWN = 2'd2
    } vote_e;
endpackage

// File: rtl/occ_vote_observer.sv
module occ_vote_observer
    import occ_rate_pkg::*;
#(
    parameter int OCC_W   = 5,
    parameter int LOW_TH  = 2,
    parameter int HIGH_TH = 14
) (
    input  logic [OCC_W-1:0] occupancy,
    output vote_e            vote
);
    localparam logic [OCC_W-1:0] LOW_V  = OCC_W'(LOW_TH);
    localparam logic [OCC_W-1:0] HIGH_V = OCC_W'(HIGH_TH);

    always_comb begin
        if (occupancy < LOW_V) begin
            vote = VOTE_DOWN;
        end else if (occupancy > HIGH_V) begin
            vote = VOTE_UP;
        end else begin
            vote = VOTE_NONE;
        end
    end
endmodule

// File: rtl/occ_vote_integrator.sv
module occ_vote_integrator
    import occ_rate_pkg::*;
#(
    parameter int FRAME_LEN = 256,
    parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iter_pulse,
    input  vote_e            vote,
    input  logic             freeze,
    input  logic             clear,
    output logic             frame_done,
    output logic [CNT_W-1:0] up_sum,
    output logic [CNT_W-1:0] dn_sum
);
    localparam int FC_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam logic [FC_W-1:0] LAST_ITER = FC_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [FC_W-1:0]  iter;
        logic [CNT_W-1:0] up;
        logic [CNT_W-1:0] dn;
    } integ_t;

    integ_t st_d, st_q;
    logic   take;

    always_comb begin
        take       = iter_pulse && !freeze;
        frame_done = take && (st_q.iter == LAST_ITER);
        up_sum     = st_q.up + CNT_W'(take && (vote == VOTE_UP));
        dn_sum     = st_q.dn + CNT_W'(take && (vote == VOTE_DOWN));

        st_d = st_q;
        if (clear || frame_done) begin
            st_d = '0;
        end else if (take) begin
            st_d.iter = st_q.iter + FC_W'(1);
            st_d.up   = up_sum;
            st_d.dn   = dn_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/occ_step_decider.sv
module occ_step_decider #(
    parameter int IDX_W      = 2,
    parameter int CNT_W      = 9,
    parameter int VOTE_LIMIT = 187
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [CNT_W-1:0] up_sum,
    input  logic [CNT_W-1:0] dn_sum,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] min_idx,
    input  logic [IDX_W-1:0] max_idx,
    input  logic             hold_rate,
    input  logic             req_ack,
    output logic             req_valid,
    output logic [IDX_W-1:0] target_idx,
    output logic             pending,
    output logic             granted
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(VOTE_LIMIT);

    typedef struct packed {
        logic             req;
        logic [IDX_W-1:0] tgt;
    } dec_t;

    dec_t dec_d, dec_q;
    logic up_win, dn_win, can_up, can_dn;

    always_comb begin
        up_win  = up_sum > LIMIT_V;
        dn_win  = dn_sum > LIMIT_V;
        can_up  = cur_idx < max_idx;
        can_dn  = cur_idx > min_idx;
        granted = dec_q.req && req_ack;

        dec_d = dec_q;
        if (granted) begin
            dec_d.req = 1'b0;
        end else if (!dec_q.req && frame_done && !hold_rate) begin
            if (up_win && can_up) begin
                dec_d.req = 1'b1;
                dec_d.tgt = cur_idx + IDX_W'(1);
            end else if (dn_win && can_dn) begin
                dec_d.req = 1'b1;
                dec_d.tgt = cur_idx - IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign req_valid  = dec_q.req;
    assign target_idx = dec_q.tgt;
    assign pending    = dec_q.req;
endmodule

// File: rtl/occ_rate_governor.sv
module occ_rate_governor
    import occ_rate_pkg::*;
#(
    parameter int OCC_W      = 5,
    parameter int IDX_W      = 2,
    parameter int LOW_TH     = 2,
    parameter int HIGH_TH    = 14,
    parameter int FRAME_LEN  = 256,
    parameter int VOTE_LIMIT = 187
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occupancy,
    input  logic             iter_pulse,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] min_idx,
    input  logic [IDX_W-1:0] max_idx,
    input  logic             hold_rate,
    input  logic             req_ack,
    output logic             req_valid,
    output logic [IDX_W-1:0] target_idx
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    vote_e            vote;
    logic             frame_done;
    logic [CNT_W-1:0] up_sum, dn_sum;
    logic             pending, granted;

    occ_vote_observer #(
        .OCC_W(OCC_W), .LOW_TH(LOW_TH), .HIGH_TH(HIGH_TH)
    ) u_observer (
        .occupancy(occupancy),
        .vote(vote)
    );

    occ_vote_integrator #(
        .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
    ) u_integrator (
        .clk(clk), .rst_n(rst_n),
        .iter_pulse(iter_pulse), .vote(vote),
        .freeze(pending), .clear(granted),
        .frame_done(frame_done), .up_sum(up_sum), .dn_sum(dn_sum)
    );

    occ_step_decider #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .VOTE_LIMIT(VOTE_LIMIT)
    ) u_decider (
        .clk(clk), .rst_n(rst_n),
        .frame_done(frame_done), .up_sum(up_sum), .dn_sum(dn_sum),
        .cur_idx(cur_idx), .min_idx(min_idx), .max_idx(max_idx),
        .hold_rate(hold_rate), .req_ack(req_ack),
        .req_valid(req_valid), .target_idx(target_idx),
        .pending(pending), .granted(granted)
    );
endmodule

// File: rtl/occ_rate_governor_chk.sv
module occ_rate_governor_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iter_pulse,
    input logic [IDX_W-1:0] cur_idx,
    input logic [IDX_W-1:0] min_idx,
    input logic [IDX_W-1:0] max_idx,
    input logic             hold_rate,
    input logic             req_ack,
    input logic             req_valid,
    input logic [IDX_W-1:0] target_idx
);
    // R3
    rise_after_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(iter_pulse));

    // R6
    target_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> (target_idx >= $past(min_idx) && target_idx <= $past(max_idx)));

    // R7
    no_req_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> !$past(hold_rate));

    // R8
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(target_idx)));

    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    // R10
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> (target_idx == $past(cur_idx) + IDX_W'(1) ||
                              target_idx == $past(cur_idx) - IDX_W'(1)));
endmodule

bind occ_rate_governor occ_rate_governor_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .iter_pulse(iter_pulse),
    .cur_idx(cur_idx), .min_idx(min_idx), .max_idx(max_idx),
    .hold_rate(hold_rate), .req_ack(req_ack),
    .req_valid(req_valid), .target_idx(target_idx)
);

// File: tb/occ_rate_governor_bench.sv
module occ_rate_governor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 256;
    localparam int LIMIT      = 187;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] occupancy = '0;
    logic       iter_pulse = 1'b0;
    logic [1:0] cur_idx = 2'd1;
    logic [1:0] min_idx = 2'd0;
    logic [1:0] max_idx = 2'd2;
    logic       hold_rate = 1'b0;
    logic       req_ack = 1'b0;
    logic       req_valid;
    logic [1:0] target_idx;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    occ_rate_governor u_occ_rate_governor (
        .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .iter_pulse(iter_pulse),
        .cur_idx(cur_idx), .min_idx(min_idx), .max_idx(max_idx),
        .hold_rate(hold_rate), .req_ack(req_ack),
        .req_valid(req_valid), .target_idx(target_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected target per R4..R7, or -1 when no request is due.
    function automatic int expect_target(input int n_up, input int n_dn);
        if (hold_rate) return -1;
        if (n_up > LIMIT && cur_idx < max_idx) return int'(cur_idx) + 1;
        if (n_dn > LIMIT && cur_idx > min_idx) return int'(cur_idx) - 1;
        return -1;
    endfunction

    task automatic pulse(input logic [4:0] occ);
        @(negedge clk);
        occupancy  = occ;
        iter_pulse = 1'b1;
        @(negedge clk);
        iter_pulse = 1'b0;
        repeat ($urandom_range(0, 2)) begin
            occupancy = 5'($urandom_range(0, 16));   // R3: ignored off-pulse
            @(negedge clk);
        end
    endtask

    task automatic run_frame(input int n_up, input int n_dn, input bit edge_vals);
        int up_rem;
        int dn_rem;
        up_rem = n_up;
        dn_rem = n_dn;
        for (int i = 0; i < FRAME; i++) begin
            int r;
            logic [4:0] o;
            r = $urandom_range(0, FRAME - i - 1);
            if (r < up_rem) begin
                o = edge_vals ? 5'd15 : 5'($urandom_range(15, 16));
                up_rem--;
            end else if (r < up_rem + dn_rem) begin
                o = edge_vals ? 5'd1 : 5'($urandom_range(0, 1));
                dn_rem--;
            end else begin
                o = edge_vals ? ((i % 2) ? 5'd2 : 5'd14) : 5'($urandom_range(2, 14));
            end
            if (i == FRAME - 1) begin
                check(req_valid == 1'b0, "R3 no request before last iteration", int'(req_valid), 0);
            end
            pulse(o);
        end
    endtask

    task automatic finish_frame(input int n_up, input int n_dn, input string req, input int busy);
        int exp;
        exp = expect_target(n_up, n_dn);
        if (exp < 0) begin
            check(req_valid == 1'b0, req, int'(req_valid), 0);
        end else begin
            check(req_valid == 1'b1, req, int'(req_valid), 1);
            check(int'(target_idx) == exp, req, int'(target_idx), exp);
            for (int k = 0; k < busy; k++) pulse(5'($urandom_range(0, 16)));
            check(req_valid == 1'b1 && int'(target_idx) == exp, "R8 request held",
                  int'(target_idx), exp);
            @(negedge clk);
            req_ack = 1'b1;
            @(negedge clk);
            req_ack = 1'b0;
            check(req_valid == 1'b0, "R8 drop after ack", int'(req_valid), 0);
            cur_idx = target_idx;
        end
    endtask

    task automatic frame(input int n_up, input int n_dn, input bit edge_vals,
                         input string req, input int busy);
        run_frame(n_up, n_dn, edge_vals);
        finish_frame(n_up, n_dn, req, busy);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(req_valid == 1'b0, "R1 reset req", int'(req_valid), 0);
        check(target_idx == 2'd0, "R1 reset target", int'(target_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);

        frame(188, 0, 1'b1, "R4 R2 speed-up at 188 votes", 3);     // cur 1 -> 2
        frame(256, 0, 1'b0, "R6 no step above max", 0);
        cur_idx = 2'd1;
        frame(187, 0, 1'b0, "R4 187 votes no request", 0);
        frame(100, 0, 1'b0, "R9 no carry between frames", 0);
        frame(0, 188, 1'b1, "R5 slow-down at 188 votes", 2);       // cur 1 -> 0
        frame(0, 256, 1'b0, "R6 no step below min", 0);
        frame(0, 0, 1'b1, "R2 threshold values give no vote", 0);
        cur_idx = 2'd1;
        hold_rate = 1'b1;
        frame(256, 0, 1'b0, "R7 hold blocks speed-up", 0);
        frame(0, 256, 1'b0, "R7 hold blocks slow-down", 0);
        hold_rate = 1'b0;
        frame(200, 0, 1'b0, "R10 one step per frame", 300);        // pending pulses ignored
        frame(0, 256, 1'b0, "R8 fresh frame after ack", 0);

        for (int f = 0; f < 22; f++) begin
            int nu;
            int nd;
            min_idx = 2'($urandom_range(0, 1));
            max_idx = 2'($urandom_range(int'(min_idx) + 1, 2));
            cur_idx = 2'($urandom_range(int'(min_idx), int'(max_idx)));
            hold_rate = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 1) == 1) begin
                nu = $urandom_range(175, 256);
                nd = $urandom_range(0, FRAME - nu);
            end else begin
                nd = $urandom_range(175, 256);
                nu = $urandom_range(0, FRAME - nd);
            end
            frame(nu, nd, 1'b0, "R4 R5 R6 R7 random frame", $urandom_range(0, 4));
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule